// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical page address. It reads descriptors from a table tree in memory through one 32-bit memory port. The walk starts at a root table. The root descriptor points to a pointer table, the pointer descriptor points to a page table, and the page descriptor gives the physical frame. The walk starts from the supervisor root pointer when the access is privileged and from the user root pointer otherwise. A page-size select chooses between 4 KB and 8 KB pages, and this changes how the low logical index is split.

While it walks, the block sets the used and modified bits in descriptors by writing them back to memory. Lookups marked as debug never write. Write protection is collected from every level. A page descriptor can be indirect, which costs one more read. A probe request also returns a status word. A faulting walk reports the access size, direction and fetch/data type so that a handler can build its frame.

The FSM has seven states:
- `S_IDLE` accepts a request and moves to `S_TBL_RD`.
- `S_TBL_RD` reads a root or pointer descriptor. It goes to `S_TBL_WB` when the used bit must be set. Otherwise it goes to `S_TBL_RD` again for the next table level, or to `S_PG_RD`.
- `S_TBL_WB` writes the used bit and then advances in the same way as `S_TBL_RD`.
- `S_PG_RD` reads the page entry. It moves to `S_IND_RD` for an indirect entry. Otherwise it goes to `S_PG_WB` when a writeback is needed, or straight to `S_FIN`.
- `S_IND_RD` reads the indirect target and moves to `S_PG_WB` or `S_FIN`.
- `S_PG_WB` writes the page flags and moves to `S_FIN`.
- `S_FIN` pulses done and returns to `S_IDLE`.

Every failure goes directly to `S_FIN`.

Top module: `pt_walker`

## Requirements
- R1: Indexing and root choice:
  - The root entry address is {root[31:9], addr[31:25], 2'b00}. The root is the supervisor root when req_super=1, and the user root otherwise.
  - The pointer entry address is {rootdesc[31:9], addr[24:18], 2'b00}.
- R2: Page size:
  - With 4 KB pages (page_8k=0), the page entry address is {ptrdesc[31:8], addr[17:12], 2'b00} and phys_page is {desc[31:12], 12'b0}.
  - With 8 KB pages, the page entry address is {ptrdesc[31:7], addr[17:13], 2'b00} and phys_page is {desc[31:13], 13'b0}.
- R3: Invalid descriptors fault:
  - A root or pointer descriptor with bit 1 clear faults.
  - A page descriptor whose type bits [1:0] equal 0 faults.
- R4: Used bit at table levels: a root or pointer descriptor with used bit 3 clear is written back with bit 3 set. The write is skipped when req_debug=1.
- R5: Write protection:
  - Bit 2 at any level removes write permission (may_write=0).
  - A store (req_kind=1) faults at the level where protection is first seen, after that level's writeback.
- R6: Indirect page descriptor: a page descriptor of type 2 causes one more read at {desc[31:2], 2'b00}. That word is the page descriptor, and any flag writeback goes to that address.
- R7: Page flag writeback:
  - For a store to an unprotected page, bits 3 (used) and 4 (modified) are both set if either is clear.
  - For any other access, only bit 3 is set if it is clear.
  - The write is skipped when req_debug=1.
- R8: A page with bit 7 (supervisor-only) set faults when req_super=0.
- R9: A memory error on any descriptor read or write ends the walk with a fault. No further memory access follows.
- R10: Probe status word:
  - When req_probe=0, probe_status is 0.
  - When req_probe=1, bit 2 holds the accumulated write protection.
  - Once a page descriptor has been taken, [31:12] hold the physical address bits 31:12, bit 7 holds S, bit 4 holds M and bit 3 holds U as read, and bit 0 is set. All other bits are 0.
- R11: Fault report: while fault=1, flt_size equals req_size, flt_write equals (req_kind==1) and flt_fetch equals (req_kind==2). All three are 0 when there is no fault.
- R12: Handshakes:
  - req_ready is high only in idle.
  - done is a single-cycle pulse.
  - mem_req, mem_addr and mem_we hold steady until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | New translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 32 | Logical address |
| req_kind | input | 2 | 0 read, 1 store, 2 fetch |
| req_size | input | 2 | Access size code, passed to the fault report |
| req_super | input | 1 | Privileged access |
| req_probe | input | 1 | Probe request, fills the status word |
| req_debug | input | 1 | Debug lookup, no descriptor writes |
| root_user | input | 32 | User root table pointer |
| root_super | input | 32 | Supervisor root table pointer |
| page_8k | input | 1 | 1 selects 8 KB pages |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with mem_ready |
| done | output | 1 | Walk complete (one cycle) |
| fault | output | 1 | Walk failed, valid with done |
| phys_page | output | 32 | Physical page address |
| may_write | output | 1 | Write permitted |
| probe_status | output | 32 | Probe status word |
| flt_size | output | 2 | Faulting access size |
| flt_write | output | 1 | Faulting access was a store |
| flt_fetch | output | 1 | Faulting access was a fetch |

## Verification
The hardest cases to reach from the ports are a memory error that lands on a writeback and not on a read, and a protected table level met during a store with an unset used bit. Only certain descriptor combinations lead the walker there. The bench builds a fresh table chain for every request with randomly chosen flag bits. It aims the injected error at one of the entry addresses it has just computed, in either read or write mode. Directed chains pin down the indirect, debug, probe and 8 KB cases. A bench model walks a shadow copy of memory to predict the outputs and the final memory image.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W = 32;

    // descriptor bit positions
    localparam int B_VALID = 1;
    localparam int B_WP    = 2;
    localparam int B_USED  = 3;
    localparam int B_MOD   = 4;
    localparam int B_SUP   = 7;

    localparam logic [1:0] PG_INVALID  = 2'd0;
    localparam logic [1:0] PG_INDIRECT = 2'd2;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_STORE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TBL_RD,
        S_TBL_WB,
        S_PG_RD,
        S_IND_RD,
        S_PG_WB,
        S_FIN
    } ptw_state_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int RB = 7,
    parameter int PB = 7,
    parameter int PS = 12
) (
    input  logic [31:0] vaddr,
    input  logic [31:0] root_base,
    input  logic [31:0] desc,
    input  logic        big_page,
    output logic [31:0] root_ent,
    output logic [31:0] ptr_ent,
    output logic [31:0] pg_ent
);
    localparam int PLO = 32 - RB - PB;  // lowest pointer-index bit
    localparam int GS  = PLO - PS;      // page index width, small pages

    always_comb begin
        root_ent = {root_base[31:RB+2], vaddr[31:PLO+PB], 2'b00};
        ptr_ent  = {desc[31:PB+2], vaddr[PLO+PB-1:PLO], 2'b00};
        if (big_page)
            pg_ent = {desc[31:GS+1], vaddr[PLO-1:PS+1], 2'b00};
        else
            pg_ent = {desc[31:GS+2], vaddr[PLO-1:PS], 2'b00};
    end

    logic unused_bits;
    assign unused_bits = ^{vaddr[PS-1:0], root_base[RB+1:0], desc[GS:0]};
endmodule

// File: rtl/ptw_page_eval.sv
module ptw_page_eval
    import ptw_pkg::*;
#(
    parameter int PS = 12
) (
    input  logic [31:0] desc,
    input  logic        wp_in,
    input  logic        is_store,
    input  logic        is_super,
    input  logic        big_page,
    input  logic        probe,
    output logic        wp_all,
    output logic        wb_need,
    output logic [31:0] wb_data,
    output logic        deny,
    output logic [31:0] phys,
    output logic [31:0] status
);
    logic dirty_path;

    always_comb begin
        wp_all     = wp_in | desc[B_WP];
        dirty_path = is_store & ~wp_all;
        wb_data    = desc;
        wb_data[B_USED] = 1'b1;
        if (dirty_path) wb_data[B_MOD] = 1'b1;
        wb_need    = (wb_data != desc);
        deny       = (is_store & wp_all) | (desc[B_SUP] & ~is_super);
        if (big_page) phys = {desc[31:PS+1], {(PS+1){1'b0}}};
        else          phys = {desc[31:PS], {PS{1'b0}}};
        if (probe)
            status = {phys[31:12], 4'b0000, desc[B_SUP], 2'b00, desc[B_MOD],
                      desc[B_USED], wp_all, 1'b0, 1'b1};
        else
            status = '0;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ROOT_IDX_W = 7,
    parameter int PTR_IDX_W  = 7,
    parameter int PAGE_SHIFT = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_size,
    input  logic        req_super,
    input  logic        req_probe,
    input  logic        req_debug,
    input  logic [31:0] root_user,
    input  logic [31:0] root_super,
    input  logic        page_8k,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ready,
    input  logic        mem_err,
    output logic        done,
    output logic        fault,
    output logic [31:0] phys_page,
    output logic        may_write,
    output logic [31:0] probe_status,
    output logic [1:0]  flt_size,
    output logic        flt_write,
    output logic        flt_fetch
);
    ptw_state_e  st_q, st_d;
    logic        lvl_q, lvl_d;
    logic [31:0] va_q, va_d, ent_q, ent_d, desc_q, desc_d;
    logic [31:0] stat_q, stat_d, phys_q, phys_d;
    logic [1:0]  kind_q, kind_d, size_q, size_d;
    logic        sup_q, sup_d, prb_q, prb_d, dbg_q, dbg_d, big_q, big_d;
    logic        wp_q, wp_d, flt_q, flt_d, mw_q, mw_d;

    logic [31:0] ix_va, ix_root, tbl_src, pg_src;
    logic [31:0] root_ent, ptr_ent, pg_ent;
    logic        is_store, tbl_wp;
    logic        ev_wp, ev_need, ev_deny;
    logic [31:0] ev_wb, ev_phys, ev_stat;

    assign is_store = (kind_q == KIND_STORE);
    assign ix_va    = (st_q == S_IDLE) ? req_addr : va_q;
    assign ix_root  = req_super ? root_super : root_user;
    assign tbl_src  = (st_q == S_TBL_WB) ? desc_q : mem_rdata;
    assign pg_src   = (st_q == S_PG_WB) ? desc_q : mem_rdata;
    assign tbl_wp   = wp_q | tbl_src[B_WP];

    ptw_index #(.RB(ROOT_IDX_W), .PB(PTR_IDX_W), .PS(PAGE_SHIFT)) u_index (
        .vaddr(ix_va), .root_base(ix_root), .desc(tbl_src), .big_page(big_q),
        .root_ent(root_ent), .ptr_ent(ptr_ent), .pg_ent(pg_ent)
    );

    ptw_page_eval #(.PS(PAGE_SHIFT)) u_eval (
        .desc(pg_src), .wp_in(wp_q), .is_store(is_store), .is_super(sup_q),
        .big_page(big_q), .probe(prb_q), .wp_all(ev_wp), .wb_need(ev_need),
        .wb_data(ev_wb), .deny(ev_deny), .phys(ev_phys), .status(ev_stat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;  lvl_q <= 1'b0;  va_q <= '0;  ent_q <= '0;
            desc_q <= '0;    stat_q <= '0;   phys_q <= '0;
            kind_q <= '0;    size_q <= '0;   sup_q <= 1'b0; prb_q <= 1'b0;
            dbg_q <= 1'b0;   big_q <= 1'b0;  wp_q <= 1'b0;  flt_q <= 1'b0;
            mw_q <= 1'b0;
        end else begin
            st_q <= st_d;    lvl_q <= lvl_d; va_q <= va_d;  ent_q <= ent_d;
            desc_q <= desc_d; stat_q <= stat_d; phys_q <= phys_d;
            kind_q <= kind_d; size_q <= size_d; sup_q <= sup_d; prb_q <= prb_d;
            dbg_q <= dbg_d;  big_q <= big_d; wp_q <= wp_d;  flt_q <= flt_d;
            mw_q <= mw_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;   lvl_d = lvl_q; va_d = va_q;   ent_d = ent_q;
        desc_d = desc_q; stat_d = stat_q; phys_d = phys_q;
        kind_d = kind_q; size_d = size_q; sup_d = sup_q; prb_d = prb_q;
        dbg_d = dbg_q; big_d = big_q; wp_d = wp_q; flt_d = flt_q; mw_d = mw_q;

        unique case (st_q)
            S_IDLE: if (req_valid) begin
                va_d = req_addr;   kind_d = req_kind; size_d = req_size;
                sup_d = req_super; prb_d = req_probe; dbg_d = req_debug;
                big_d = page_8k;   ent_d = root_ent;  lvl_d = 1'b0;
                wp_d = 1'b0; flt_d = 1'b0; mw_d = 1'b0;
                stat_d = '0; phys_d = '0;
                st_d = S_TBL_RD;
            end
            S_TBL_RD, S_TBL_WB: if (mem_ready) begin
                if (mem_err || (st_q == S_TBL_RD && !mem_rdata[B_VALID])) begin
                    flt_d = 1'b1; st_d = S_FIN;
                end else if (st_q == S_TBL_RD && !mem_rdata[B_USED] && !dbg_q) begin
                    desc_d = mem_rdata; st_d = S_TBL_WB;
                end else begin
                    wp_d = tbl_wp;
                    if (prb_q) stat_d[B_WP] = tbl_wp;
                    if (tbl_wp && is_store) begin
                        flt_d = 1'b1; st_d = S_FIN;
                    end else if (!lvl_q) begin
                        ent_d = ptr_ent; lvl_d = 1'b1; st_d = S_TBL_RD;
                    end else begin
                        ent_d = pg_ent; st_d = S_PG_RD;
                    end
                end
            end
            S_PG_RD, S_IND_RD, S_PG_WB: if (mem_ready) begin
                if (mem_err || (st_q == S_PG_RD && mem_rdata[1:0] == PG_INVALID)) begin
                    flt_d = 1'b1; st_d = S_FIN;
                end else if (st_q == S_PG_RD && mem_rdata[1:0] == PG_INDIRECT) begin
                    ent_d = {mem_rdata[31:2], 2'b00}; st_d = S_IND_RD;
                end else if (st_q != S_PG_WB && ev_need && !dbg_q) begin
                    desc_d = mem_rdata; st_d = S_PG_WB;
                end else begin
                    wp_d = ev_wp; stat_d = ev_stat; flt_d = ev_deny;
                    phys_d = ev_deny ? '0 : ev_phys;
                    mw_d = ~ev_deny & ~ev_wp;
                    st_d = S_FIN;
                end
            end
            S_FIN: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (st_q == S_IDLE);
        mem_req   = (st_q != S_IDLE) && (st_q != S_FIN);
        mem_we    = (st_q == S_TBL_WB) || (st_q == S_PG_WB);
        mem_addr  = ent_q;
        mem_wdata = ev_wb;
        if (st_q == S_TBL_WB) begin
            mem_wdata = desc_q;
            mem_wdata[B_USED] = 1'b1;
        end
        done         = (st_q == S_FIN);
        fault        = done & flt_q;
        phys_page    = phys_q;
        may_write    = mw_q;
        probe_status = stat_q;
        flt_size     = fault ? size_q : 2'b00;
        flt_write    = fault & (kind_q == KIND_STORE);
        flt_fetch    = fault & (kind_q == KIND_FETCH);
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_debug,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ready,
    input logic        done,
    input logic        fault,
    input logic        may_write,
    input logic [1:0]  flt_size,
    input logic        flt_write,
    input logic        flt_fetch
);
    logic dbg_walk;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbg_walk <= 1'b0;
        else if (req_valid && req_ready) dbg_walk <= req_debug;
        else if (done) dbg_walk <= 1'b0;
    end

    assert_debug_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_walk |-> !mem_we);
    assert_wb_sets_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[3]);
    assert_fault_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !may_write);
    assert_fault_info_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (flt_size == 2'b00 && !flt_write && !flt_fetch));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind pt_walker ptw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_debug(req_debug), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .done(done), .fault(fault), .may_write(may_write), .flt_size(flt_size),
    .flt_write(flt_write), .flt_fetch(flt_fetch)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RU = 32'h0001_0000;
    localparam logic [31:0] RS = 32'h0002_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_super = 1'b0, req_probe = 1'b0, req_debug = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0, req_size = '0;
    logic page_8k = 1'b0;
    logic req_ready, mem_req, mem_we, done, fault, may_write, flt_write, flt_fetch;
    logic [31:0] mem_addr, mem_wdata, phys_page, probe_status;
    logic [1:0]  flt_size;
    logic [31:0] mem_rdata = '0;
    logic mem_ready = 1'b0, mem_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_size(req_size),
        .req_super(req_super), .req_probe(req_probe), .req_debug(req_debug),
        .root_user(RU), .root_super(RS), .page_8k(page_8k),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
        .done(done), .fault(fault), .phys_page(phys_page), .may_write(may_write),
        .probe_status(probe_status), .flt_size(flt_size), .flt_write(flt_write),
        .flt_fetch(flt_fetch)
    );

    logic [31:0] mem  [logic [31:0]];
    logic [31:0] refm [logic [31:0]];
    int checks = 0, errs = 0, wait_cnt = 0, err_mode = 0;
    logic [31:0] err_addr = '0;
    logic [31:0] re, pe, ge, ie;
    logic        e_fault, e_mw;
    logic [31:0] e_phys, e_stat;

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] rd_ref(input logic [31:0] a);
        return refm.exists(a) ? refm[a] : 32'h0;
    endfunction

    // memory responder
    always @(posedge clk) begin
        #1;
        if (mem_ready) begin
            mem_ready = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        end else if (mem_req) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
                if (mem_we) begin
                    if (err_mode == 2 && mem_addr == err_addr) mem_err = 1'b1;
                    else mem[mem_addr] = mem_wdata;
                end else begin
                    mem_err = (err_mode == 1 && mem_addr == err_addr);
                    mem_rdata = rd_mem(mem_addr);
                end
                mem_ready = 1'b1;
                wait_cnt = $urandom_range(0, 2);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference walk over the shadow memory
    task automatic model(input logic [31:0] va, input logic [1:0] kind, input bit sup,
                         input bit prb, input bit dbg, input bit big);
        logic [31:0] e, d, nd;
        bit wp = 0, st = (kind == 2'd1);
        e_fault = 1; e_mw = 0; e_phys = 0; e_stat = 0;
        e = {(sup ? RS[31:9] : RU[31:9]), va[31:25], 2'b00};
        for (int lv = 0; lv < 2; lv++) begin
            if (err_mode == 1 && e == err_addr) return;
            d = rd_ref(e);
            if (!d[1]) return;
            if (!d[3] && !dbg) begin
                if (err_mode == 2 && e == err_addr) return;
                refm[e] = d | 32'h8;
            end
            wp = wp | d[2];
            if (prb) e_stat[2] = wp;
            if (wp && st) return;
            if (lv == 0) e = {d[31:9], va[24:18], 2'b00};
            else e = big ? {d[31:7], va[17:13], 2'b00} : {d[31:8], va[17:12], 2'b00};
        end
        if (err_mode == 1 && e == err_addr) return;
        d = rd_ref(e);
        if (d[1:0] == 2'd0) return;
        if (d[1:0] == 2'd2) begin
            e = {d[31:2], 2'b00};
            if (err_mode == 1 && e == err_addr) return;
            d = rd_ref(e);
        end
        wp = wp | d[2];
        nd = d | 32'h8 | ((st && !wp) ? 32'h10 : 32'h0);
        if (nd != d && !dbg) begin
            if (err_mode == 2 && e == err_addr) return;
            refm[e] = nd;
        end
        e_phys  = big ? (d & 32'hFFFF_E000) : (d & 32'hFFFF_F000);
        if (prb) e_stat = {e_phys[31:12], 4'b0, d[7], 2'b0, d[4], d[3], wp, 1'b0, 1'b1};
        e_fault = (st && wp) || (d[7] && !sup);
        if (e_fault) e_phys = 0;
        e_mw = !e_fault && !wp;
    endtask

    // lay out one table chain for va
    task automatic build(input logic [31:0] va, input bit sup, input bit big,
                         input logic [8:0] rlow, input logic [6:0] plow,
                         input logic [31:0] pgd, input logic [31:0] indd);
        logic [31:0] ptb, pgt, rd, pd, ind, gd;
        ptb = 32'h0010_0000 + ($urandom_range(0, 255) << 9);
        pgt = 32'h0020_0000 + ($urandom_range(0, 255) << 8);
        ind = 32'h0030_0000 + ($urandom_range(0, 1023) << 2);
        rd = ptb | {23'b0, rlow};
        pd = pgt | {25'b0, plow};
        re = {(sup ? RS[31:9] : RU[31:9]), va[31:25], 2'b00};
        pe = {rd[31:9], va[24:18], 2'b00};
        ge = big ? {pd[31:7], va[17:13], 2'b00} : {pd[31:8], va[17:12], 2'b00};
        ie = ind;
        gd = pgd;
        if (gd[1:0] == 2'd2) gd = {ind[31:2], 2'b10};
        mem[re] = rd; mem[pe] = pd; mem[ge] = gd; mem[ie] = indd;
    endtask

    task automatic run(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] size,
                       input bit sup, input bit prb, input bit dbg, input bit big, input string tag);
        int wd = 0;
        bit memok = 1;
        refm = mem;
        model(va, kind, sup, prb, dbg, big);
        @(negedge clk);
        req_addr = va; req_kind = kind; req_size = size; req_super = sup;
        req_probe = prb; req_debug = dbg; page_8k = big; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R12 busy", {31'b0, req_ready}, 32'h0);
        while (!done && wd < 2000) begin @(negedge clk); wd++; end
        if (!done) begin
            check(1'b0, "watchdog walk", 32'h0, 32'h1);
            return;
        end
        check(fault == e_fault, {tag, " fault"}, {31'b0, fault}, {31'b0, e_fault});
        check(phys_page == e_phys, "R2 phys_page", phys_page, e_phys);
        check(may_write == e_mw, "R5 may_write", {31'b0, may_write}, {31'b0, e_mw});
        check(probe_status == e_stat, "R10 probe_status", probe_status, e_stat);
        check({flt_size, flt_write, flt_fetch} ==
              (e_fault ? {size, kind == 2'd1, kind == 2'd2} : 4'b0),
              "R11 fault info", {28'b0, flt_size, flt_write, flt_fetch},
              e_fault ? {28'b0, size, kind == 2'd1, kind == 2'd2} : 32'h0);
        foreach (refm[k]) if (rd_mem(k) != refm[k]) memok = 0;
        if (mem.num() != refm.num()) memok = 0;
        check(memok, {tag, " R7 memory image"}, mem.num(), refm.num());
        @(negedge clk);
        check(done == 1'b0, "R12 done pulse", {31'b0, done}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        logic [31:0] va;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done && !mem_req && !fault, "R12 reset state",
              {28'b0, req_ready, done, mem_req, fault}, 32'h8);

        // R1 user read, 4 KB
        va = 32'h1234_5678;
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h00AB_C009, 0); run(va, 0, 2, 0, 0, 0, 0, "R1");
        // R1 supervisor root, R2 8 KB
        build(va, 1, 1, 9'h00A, 7'h0A, 32'h00AB_D001, 0); run(va, 0, 2, 1, 0, 0, 1, "R2");
        // R3 invalid root / invalid page
        build(va, 0, 0, 9'h000, 7'h0A, 32'h00AB_C009, 0); run(va, 0, 1, 0, 0, 0, 0, "R3");
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h00AB_C000, 0); run(va, 0, 1, 0, 0, 0, 0, "R3");
        // R4 / R7 debug store with clear used bits: no writes
        build(va, 0, 0, 9'h002, 7'h02, 32'h00AB_C001, 0); run(va, 1, 2, 0, 0, 1, 0, "R4");
        // R4 used written back on a plain read
        build(va, 0, 0, 9'h002, 7'h02, 32'h00AB_C001, 0); run(va, 0, 2, 0, 0, 0, 0, "R4");
        // R5 protected root with store faults; protected pointer on read gives no write
        build(va, 0, 0, 9'h006, 7'h0A, 32'h00AB_C009, 0); run(va, 1, 2, 0, 1, 0, 0, "R5");
        build(va, 0, 0, 9'h00A, 7'h0E, 32'h00AB_C009, 0); run(va, 0, 2, 0, 1, 0, 0, "R5");
        // R6 indirect page descriptor
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h0000_0002, 32'h0777_7001); run(va, 1, 2, 0, 1, 0, 0, "R6");
        // R7 store sets modified and used
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h00AB_C009, 0); run(va, 1, 2, 0, 0, 0, 0, "R7");
        // R8 supervisor-only page from user mode
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h00AB_C089, 0); run(va, 0, 2, 0, 1, 0, 0, "R8");
        // R9 memory error on read and on writeback
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h00AB_C009, 0);
        err_mode = 1; err_addr = pe; run(va, 0, 2, 0, 0, 0, 0, "R9");
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h00AB_C001, 0);
        err_mode = 2; err_addr = ge; run(va, 1, 2, 0, 0, 0, 0, "R9");
        err_mode = 0;
        // R10 probe, R11 fetch fault info
        build(va, 1, 0, 9'h00A, 7'h0A, 32'h00AB_C099, 0); run(va, 0, 0, 1, 1, 0, 0, "R10");
        build(va, 0, 0, 9'h00A, 7'h0A, 32'h0000_0000, 0); run(va, 2, 3, 0, 0, 0, 0, "R11");

        // constrained random chains
        for (int n = 0; n < 300; n++) begin
            logic [31:0] pgd, indd, rl, pl;
            bit sup, big;
            va = $urandom; sup = $urandom_range(0, 1); big = $urandom_range(0, 1);
            rl = $urandom; rl[1] = ($urandom_range(0, 15) != 0); rl[2] = ($urandom_range(0, 7) == 0);
            pl = $urandom; pl[1] = ($urandom_range(0, 15) != 0); pl[2] = ($urandom_range(0, 7) == 0);
            pgd = $urandom; pgd[2] = ($urandom_range(0, 7) == 0); pgd[7] = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 7))
                0: pgd[1:0] = 2'd0;
                1, 2: pgd[1:0] = 2'd2;
                default: pgd[1:0] = $urandom_range(0, 1) ? 2'd1 : 2'd3;
            endcase
            indd = $urandom; indd[0] = 1'b1; indd[2] = ($urandom_range(0, 7) == 0);
            indd[7] = ($urandom_range(0, 3) == 0);
            build(va, sup, big, rl[8:0], pl[6:0], pgd, indd);
            err_mode = 0;
            if ($urandom_range(0, 4) == 0) begin
                err_mode = $urandom_range(1, 2);
                case ($urandom_range(0, 3))
                    0: err_addr = re; 1: err_addr = pe; 2: err_addr = ge; default: err_addr = ie;
                endcase
            end
            run(va, 2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), sup,
                $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0, big, "R1 random");
        end
        err_mode = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule